// File: doc/BRIEF.md
# I2C SCL Clock Divider

This block turns the peripheral clock into the bit timing of an I2C master. A prescaler divides the peripheral clock by one plus a 3-bit value to make an internal tick; the tick should stay below 20 MHz. A phase counter then counts ticks through one SCL period. The period is a fixed base of 20 ticks, plus 8 ticks for each unit of a 6-bit gap count, plus a small programmable compensation term. That term accounts for SCL rise time, fall time and internal delay, and software sets it.

The period splits into a low phase of floor(P/2) ticks and a high phase that takes the rest. Three single-cycle strobes tell the bit engine where it is in the period: one where SCL falls, one at the middle of the low phase where SDA may change, and one at the middle of the high phase where SDA is sampled. A new divider setting is captured only at a period boundary, so no period is ever cut short.

The block carries control values only, so it has no valid/ready stream; every pin is a plain level or strobe. Software computes the divider value from the target bus speed.

Top module: `scl_clk_divider`

## Requirements
- R1: While `en_i` is high, `tick_o` is high for one cycle out of every (prescale + 1) cycles, where prescale is `div_cfg_i[2:0]`. The first tick comes (prescale + 1) cycles after enabling. `tick_o` is low while `en_i` is low.
- R2: One SCL period lasts 20 + 8·gap + comp ticks, where gap is `div_cfg_i[8:3]` (0 to 63) and comp is `comp_i`. The distance between two `fall_stb_o` pulses is (prescale + 1) times that number of clock cycles.
- R3: `scl_o` (1 = released high, 0 = driven low) is low for the first floor(P/2) ticks of a period and high for the remaining P − floor(P/2) ticks. The low phase lasts (prescale + 1)·floor(P/2) clock cycles.
- R4: `fall_stb_o` pulses for one cycle in the same cycle that `scl_o` first shows low, which is the start of every period.
- R5: `chg_stb_o` pulses at tick index floor(L/2) of the period, while SCL is low. `smp_stb_o` pulses at tick index L + floor((P−L)/2), while SCL is high (L = floor(P/2)). All outputs except `tick_o` are registered and change one clock after the tick that moves them.
- R6: Changes to `div_cfg_i` or `comp_i` while enabled have no effect until the tick that starts the next period. That period and the ones after it use the new value.
- R7: While `en_i` is low, `scl_o` is high and all strobes are low, and the period restarts. The first tick after enabling starts a new period with a falling edge.
- R8: After reset, `scl_o` is high and `tick_o`, `fall_stb_o`, `chg_stb_o` and `smp_stb_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Master enable; low holds SCL released |
| div_cfg_i | input | 9 | Divider setting: [2:0] prescale, [8:3] gap count |
| comp_i | input | 4 | Rise/fall/delay compensation in ticks |
| tick_o | output | 1 | Internal clock tick |
| scl_o | output | 1 | SCL level, 1 = released |
| fall_stb_o | output | 1 | SCL falling-edge strobe |
| chg_stb_o | output | 1 | Data-change point strobe |
| smp_stb_o | output | 1 | Sampling point strobe |

## Verification
The assertions assume that the settings change only in the ways a master would use. Those changes may land at any cycle and are captured only at a period boundary. The assertions also assume that `en_i` holds its level across a clock edge, because the bench drives it a nanosecond after the rising edge. From that, the assertions require the prescale count never to exceed its captured limit, and the captured settings never to move inside a period. The stimulus changes the settings in the middle of a period, toggles the enable in the middle of a phase, and covers the smallest period, an odd period and the largest setting. A behavioural reference model is compared against the outputs on every cycle.

// File: rtl/scl_div_pkg.sv
package scl_div_pkg;
  localparam int DEF_PRE_W  = 3;
  localparam int DEF_GAP_W  = 6;
  localparam int DEF_COMP_W = 4;
  localparam int DEF_BASE   = 20;
  localparam int DEF_STEP   = 8;
endpackage

// File: rtl/scl_prescaler.sv
module scl_prescaler #(
  parameter int PRE_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic [PRE_W-1:0] limit_i,
  output logic             tick_o
);
  logic [PRE_W-1:0] cnt_q;

  assign tick_o = en_i && (cnt_q == limit_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt_q <= '0;
    else if (!en_i || tick_o)  cnt_q <= '0;
    else                       cnt_q <= cnt_q + 1'b1;
  end

  // The limit only moves at a period boundary or when idle, so the count never passes it.
  p_cnt_in_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
    en_i |-> cnt_q <= limit_i);
  p_tick_isolated_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_o && limit_i != '0) |=> !tick_o);
endmodule

// File: rtl/scl_phase_gen.sv
module scl_phase_gen #(
  parameter int PRE_W  = 3,
  parameter int GAP_W  = 6,
  parameter int COMP_W = 4,
  parameter int BASE   = 20,
  parameter int STEP   = 8,
  parameter int CNT_W  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic              tick_i,
  input  logic [PRE_W+GAP_W-1:0] cfg_i,
  input  logic [COMP_W-1:0] comp_i,
  output logic [PRE_W-1:0]  pre_o,
  output logic              scl_o,
  output logic              fall_o,
  output logic              chg_o,
  output logic              smp_o
);
  logic [GAP_W-1:0]  gap_q;
  logic [COMP_W-1:0] comp_q;
  logic [PRE_W-1:0]  pre_q;
  logic [CNT_W-1:0]  cnt_q, nxt;
  logic              run_q;
  logic [CNT_W-1:0]  period, low_len, high_len, chg_pt, smp_pt;
  logic              boundary;

  always_comb begin
    period   = CNT_W'(BASE) + CNT_W'(STEP) * CNT_W'(gap_q) + CNT_W'(comp_q);
    low_len  = period >> 1;
    high_len = period - low_len;
    chg_pt   = low_len >> 1;
    smp_pt   = low_len + (high_len >> 1);
    if (!run_q || cnt_q == period - 1'b1) nxt = '0;
    else                                   nxt = cnt_q + 1'b1;
    boundary = tick_i && (nxt == '0);
  end

  assign pre_o = pre_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q <= '0; comp_q <= '0; pre_q <= '0;
      cnt_q <= '0; run_q <= 1'b0;
      scl_o <= 1'b1; fall_o <= 1'b0; chg_o <= 1'b0; smp_o <= 1'b0;
    end else if (!en_i) begin
      {gap_q, pre_q} <= cfg_i;
      comp_q <= comp_i;
      cnt_q  <= '0;
      run_q  <= 1'b0;
      scl_o  <= 1'b1;
      fall_o <= 1'b0; chg_o <= 1'b0; smp_o <= 1'b0;
    end else begin
      fall_o <= tick_i && (nxt == '0);
      chg_o  <= tick_i && (nxt == chg_pt);
      smp_o  <= tick_i && (nxt == smp_pt);
      if (tick_i) begin
        cnt_q <= nxt;
        run_q <= 1'b1;
        scl_o <= (nxt >= low_len);
      end
      if (boundary) begin
        {gap_q, pre_q} <= cfg_i;
        comp_q <= comp_i;
      end
    end
  end

  p_fall_at_edge_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(scl_o) |-> fall_o);
  p_fall_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    fall_o |-> !scl_o);
  p_chg_in_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    chg_o |-> !scl_o);
  p_smp_in_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
    smp_o |-> scl_o);
  p_strobe_after_tick_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (fall_o || chg_o || smp_o) |-> $past(tick_i));
  p_cnt_in_period_r2: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> cnt_q < period);
  p_cfg_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && !boundary) |=> ($stable(gap_q) && $stable(comp_q) && $stable(pre_q)));
  p_idle_released_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> (scl_o && !fall_o && !chg_o && !smp_o));
endmodule

// File: rtl/scl_clk_divider.sv
module scl_clk_divider
  import scl_div_pkg::*;
#(
  parameter int PRE_W  = DEF_PRE_W,
  parameter int GAP_W  = DEF_GAP_W,
  parameter int COMP_W = DEF_COMP_W,
  parameter int BASE   = DEF_BASE,
  parameter int STEP   = DEF_STEP
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   en_i,
  input  logic [PRE_W+GAP_W-1:0] div_cfg_i,
  input  logic [COMP_W-1:0]      comp_i,
  output logic                   tick_o,
  output logic                   scl_o,
  output logic                   fall_stb_o,
  output logic                   chg_stb_o,
  output logic                   smp_stb_o
);
  localparam int MAX_P = BASE + STEP * ((1 << GAP_W) - 1) + (1 << COMP_W) - 1;
  localparam int CNT_W = $clog2(MAX_P + 1);

  logic [PRE_W-1:0] pre_lim;

  scl_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .en_i(en_i), .limit_i(pre_lim), .tick_o(tick_o)
  );

  scl_phase_gen #(
    .PRE_W(PRE_W), .GAP_W(GAP_W), .COMP_W(COMP_W),
    .BASE(BASE), .STEP(STEP), .CNT_W(CNT_W)
  ) u_phase (
    .clk(clk), .rst_n(rst_n), .en_i(en_i), .tick_i(tick_o),
    .cfg_i(div_cfg_i), .comp_i(comp_i), .pre_o(pre_lim),
    .scl_o(scl_o), .fall_o(fall_stb_o), .chg_o(chg_stb_o), .smp_o(smp_stb_o)
  );
endmodule

// File: tb/test_scl_clk_divider.sv
module test_scl_clk_divider;
  logic clk = 1'b0, rst_n = 1'b0, en = 1'b0;
  logic [2:0] pre = '0;
  logic [5:0] gap = '0;
  logic [3:0] comp = '0;
  logic tick, scl, fall, chg, smp;
  int n_cmp = 0, n_bad = 0, cyc = 0;
  string tag = "";

  always #2 clk = ~clk;

  scl_clk_divider i_scl_clk_divider (
    .clk(clk), .rst_n(rst_n), .en_i(en), .div_cfg_i({gap, pre}), .comp_i(comp),
    .tick_o(tick), .scl_o(scl), .fall_stb_o(fall), .chg_stb_o(chg), .smp_stb_o(smp)
  );

  // behavioural reference model
  int mp, mc, lp, lg, lc, per, lo, hi, nc;
  bit ms, escl, ef, ec, esm;
  initial begin mp = 0; mc = 0; lp = 0; lg = 0; lc = 0; ms = 0; escl = 1; ef = 0; ec = 0; esm = 0; end

  always @(posedge clk) begin
    if (!rst_n) begin
      mp = 0; mc = 0; ms = 0; lp = 0; lg = 0; lc = 0; escl = 1; ef = 0; ec = 0; esm = 0;
    end else if (!en) begin
      mp = 0; mc = 0; ms = 0; lp = pre; lg = gap; lc = comp; escl = 1; ef = 0; ec = 0; esm = 0;
    end else begin
      ef = 0; ec = 0; esm = 0;
      if (mp == lp) begin
        per = 20 + 8 * lg + lc; lo = per / 2; hi = per - lo;
        nc = ms ? ((mc == per - 1) ? 0 : mc + 1) : 0;
        escl = (nc >= lo); ef = (nc == 0); ec = (nc == lo / 2); esm = (nc == lo + hi / 2);
        mc = nc; ms = 1; mp = 0;
        if (nc == 0) begin lp = pre; lg = gap; lc = comp; end
      end else mp = mp + 1;
    end
  end

  task automatic check(string req, string what, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d at cycle %0d", req, what, act, exp, cyc);
    end
  endtask

  function automatic string pick(string dflt);
    return (tag != "") ? tag : dflt;
  endfunction

  always @(negedge clk) if (rst_n) begin
    check(pick("R1"), "tick_o", tick, int'(en && mp == lp));
    check(pick("R3"), "scl_o", scl, escl);
    check(pick("R4"), "fall_stb_o", fall, ef);
    check(pick("R5"), "chg_stb_o", chg, ec);
    check(pick("R5"), "smp_stb_o", smp, esm);
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_bad++; n_cmp++;
      $display("FAIL watchdog: actual %0d expected below 150000 cycles", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic run(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic setcfg(bit e, int p, int g, int c);
    @(posedge clk); #1;
    en = e; pre = 3'(p); gap = 6'(g); comp = 4'(c);
  endtask

  // R2: distance between falling-edge strobes
  task automatic measure_period(string req, int exp);
    int d;
    do @(negedge clk); while (!fall);
    d = 0;
    do begin @(negedge clk); d++; end while (!fall);
    check(req, "period cycles", d, exp);
  endtask

  // R3: length of the low phase
  task automatic measure_low(int exp);
    int d;
    do @(negedge clk); while (!fall);
    d = 1;
    forever begin @(negedge clk); if (scl) break; d++; end
    check("R3", "low phase cycles", d, exp);
  endtask

  initial begin
    run(4);
    check("R8", "reset scl_o", scl, 1);
    check("R8", "reset tick_o", tick, 0);
    check("R8", "reset strobes", {fall, chg, smp}, 0);
    @(negedge clk); rst_n = 1'b1;
    run(3);
    // smallest period
    setcfg(1, 0, 0, 0);
    run(60);
    measure_period("R2", 20);
    measure_low(10);
    // change mid period
    run(7);
    tag = "R6";
    setcfg(1, 3, 2, 5);
    run(300);
    tag = "";
    measure_period("R2", 4 * 41);
    // disable mid phase, re-enable at the largest setting
    tag = "R7";
    run(33);
    setcfg(0, 3, 2, 5);
    run(12);
    check("R7", "idle scl_o", scl, 1);
    setcfg(1, 7, 63, 15);
    run(20);
    tag = "";
    measure_period("R2", 8 * 539);
    // odd period
    setcfg(1, 1, 5, 3);
    run(300);
    measure_period("R2", 2 * 63);
    measure_low(2 * 31);
    // enable toggling
    tag = "R7";
    for (int k = 0; k < 6; k++) begin
      setcfg(0, k % 4, k, k);
      run(k + 1);
      setcfg(1, k % 4, k, k);
      run(40 + 3 * k);
    end
    setcfg(0, 0, 0, 0);
    run(5);
    tag = "";
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule